// File: doc/BRIEF.md
# Machine Timer Compare Unit

This block is a core-local machine timer. It keeps a free-running 64-bit time count that moves forward by one on each cycle where the tick enable is high. It also holds a 64-bit threshold, and it drives a level interrupt toward the processor. Software reaches both 64-bit values as pairs of 32-bit words over a simple single-cycle load/store bus. The threshold can be written and read back. The time count can only be read.

The interrupt line is registered. It goes high on the clock after the count has moved strictly past the threshold, and it stays high until software moves the threshold back above the count. At reset the threshold is loaded with all ones, so no interrupt can fire before software programs it.

Top module: `mtimer_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count is loaded with parameter `CNT_INIT` (default zero), both threshold words become 0xFFFF_FFFF and `irq_timer` is 0.
- R2: On each clock with `tick_en` high the 64-bit count increases by exactly one. With `tick_en` low it keeps its value.
- R3: When the low count word is 0xFFFF_FFFF and a tick arrives, the high word increases in that same clock and the low word becomes zero.
- R4: A selected write (`bus_sel`=1, `bus_we`=1) to 0x1100_4000 replaces threshold bits 31:0, and one to 0x1100_4004 replaces bits 63:32. The other word is left unchanged. A selected read of either address returns the stored word.
- R5: A selected read (`bus_sel`=1, `bus_we`=0) of 0x1100_BFF8 returns count bits 31:0, and one of 0x1100_BFFC returns bits 63:32. The value returned is the count before the current clock edge.
- R6: Writes to 0x1100_BFF8 and 0x1100_BFFC have no effect on the count.
- R7: At each clock edge out of reset, `irq_timer` takes the value of (count > threshold), compared as unsigned numbers on the values held before that edge. Equality gives 0.
- R8: Once high, `irq_timer` stays high while the count remains above the threshold. It returns to 0 on the clock after a threshold write that leaves the threshold at or above the count.
- R9: With `bus_sel` low, a write changes nothing. `bus_rdata` is zero whenever `bus_sel` is low, `bus_we` is high, or the address matches none of the four word addresses. Addresses must match exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Advance the count by one this cycle |
| bus_sel | input | 1 | Bus access strobe |
| bus_addr | input | 32 | Byte address of the word accessed |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_timer | output | 1 | Machine timer interrupt level |

## Verification
The hardest state to reach is the carry from the low count word into the high word. Software cannot write the count, and counting up to it would take four billion ticks. The bench therefore elaborates the unit with `CNT_INIT` set 256 below the word boundary and ticks across it while reading the high word. It then places the threshold a few counts above the post-carry value, so the strict-greater edge is crossed with the high word non-zero. After that it raises the threshold again to release the level interrupt.

// File: rtl/mtimer_pkg.sv
`timescale 1ns/1ps
// mtimer_pkg: shared constants for the machine timer unit.
// Assumes a byte-addressed bus with 32-bit words, so successive words are 4 apart.
package mtimer_pkg;
    localparam int unsigned WORD_BYTES = 4;
    localparam logic [31:0] DEF_CMP_BASE = 32'h1100_4000;
    localparam logic [31:0] DEF_CNT_BASE = 32'h1100_BFF8;
endpackage

// File: rtl/mtimer_addr_dec.sv
`timescale 1ns/1ps
// mtimer_addr_dec: turns a bus address into one-hot hits, one per data word,
// for the threshold words and for the count words.
// Assumes an exact address match: partial or misaligned addresses hit nothing.
module mtimer_addr_dec
    import mtimer_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned NWORD    = 2,
    parameter logic [AW-1:0] CMP_BASE = DEF_CMP_BASE,
    parameter logic [AW-1:0] CNT_BASE = DEF_CNT_BASE
) (
    input  logic [AW-1:0]    addr,
    output logic [NWORD-1:0] cmp_hit,
    output logic [NWORD-1:0] cnt_hit
);
    // One comparator pair per word; word k sits k words above its base.
    for (genvar k = 0; k < NWORD; k++) begin : g_word
        localparam logic [AW-1:0] OFFS = AW'(k * WORD_BYTES);
        assign cmp_hit[k] = (addr == CMP_BASE + OFFS);
        assign cnt_hit[k] = (addr == CNT_BASE + OFFS);
    end
endmodule

// File: rtl/mtimer_counter.sv
`timescale 1ns/1ps
// mtimer_counter: free-running count built from DATA_W-wide words with a
// combinational carry chain, so a word rollover reaches the next word in the
// same clock as the tick.
// Assumes tick_en is synchronous to clk. The count wraps silently at the top.
module mtimer_counter #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NWORD  = 2,
    localparam int unsigned CNT_W = DATA_W * NWORD,
    parameter logic [CNT_W-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);
    logic [NWORD-1:0] carry;

    assign carry[0] = tick_en;

    for (genvar k = 0; k < NWORD; k++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Load the reset value, else step the word when the carry reaches it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= INIT[k*DATA_W +: DATA_W];
            end else if (carry[k]) begin
                word_q <= word_q + 1'b1;
            end
        end

        assign count[k*DATA_W +: DATA_W] = word_q;

        if (k + 1 < NWORD) begin : g_carry
            assign carry[k+1] = carry[k] & (&word_q);
        end
    end
endmodule

// File: rtl/mtimer_cmp_regs.sv
`timescale 1ns/1ps
// mtimer_cmp_regs: threshold storage, written one DATA_W word at a time.
// Assumes wr_hit has at most one bit set. Resets to all ones (never exceeded).
module mtimer_cmp_regs #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NWORD  = 2,
    localparam int unsigned CNT_W = DATA_W * NWORD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NWORD-1:0]  wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp
);
    for (genvar k = 0; k < NWORD; k++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Hold the word unless this word is being written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (wr_hit[k]) begin
                word_q <= wdata;
            end
        end

        assign cmp[k*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/mtimer_irq_gen.sv
`timescale 1ns/1ps
// mtimer_irq_gen: registers a strict unsigned greater-than between count and
// threshold into the interrupt level.
// Assumes both inputs are register outputs, so the compare sees a full cycle.
module mtimer_irq_gen #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    output logic             irq
);
    // Sample the comparison once per clock; equality does not raise it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= (count > cmp);
        end
    end
endmodule

// File: rtl/mtimer_unit.sv
`timescale 1ns/1ps
// mtimer_unit: machine timer with a read-only count, a word-writable threshold
// and a registered strict-greater interrupt level.
// Assumes single-cycle bus accesses. Read data is combinational from the
// registers and is zero unless the access is a selected read of a mapped word.
module mtimer_unit
    import mtimer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 64,
    parameter logic [31:0] CMP_BASE = DEF_CMP_BASE,
    parameter logic [31:0] CNT_BASE = DEF_CNT_BASE,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic [31:0]       bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_timer
);
    localparam int unsigned NWORD = CNT_W / DATA_W;

    logic [NWORD-1:0] cmp_hit;
    logic [NWORD-1:0] cnt_hit;
    logic [NWORD-1:0] cmp_wr;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] cmp_w;
    logic             rd_en;

    mtimer_addr_dec #(
        .AW(32), .NWORD(NWORD), .CMP_BASE(CMP_BASE), .CNT_BASE(CNT_BASE)
    ) u_dec (
        .addr(bus_addr), .cmp_hit(cmp_hit), .cnt_hit(cnt_hit)
    );

    mtimer_counter #(
        .DATA_W(DATA_W), .NWORD(NWORD), .INIT(CNT_INIT)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count_w)
    );

    // Only selected writes reach the threshold; count words take no writes.
    assign cmp_wr = cmp_hit & {NWORD{bus_sel & bus_we}};

    mtimer_cmp_regs #(
        .DATA_W(DATA_W), .NWORD(NWORD)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n), .wr_hit(cmp_wr), .wdata(bus_wdata), .cmp(cmp_w)
    );

    mtimer_irq_gen #(
        .CNT_W(CNT_W)
    ) u_irq (
        .clk(clk), .rst_n(rst_n), .count(count_w), .cmp(cmp_w), .irq(irq_timer)
    );

    assign rd_en = bus_sel & ~bus_we;

    // Select the addressed word for a read, zero otherwise.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NWORD; k++) begin
            if (rd_en && cnt_hit[k]) begin
                bus_rdata = count_w[k*DATA_W +: DATA_W];
            end
            if (rd_en && cmp_hit[k]) begin
                bus_rdata = cmp_w[k*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/mtimer_unit_chk.sv
`timescale 1ns/1ps
// mtimer_unit_chk: temporal checks on the timer unit, attached by bind.
// Assumes it observes the internal count and threshold buses of the top.
module mtimer_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 64,
    parameter logic [31:0] CMP_BASE = 32'h1100_4000,
    parameter logic [31:0] CNT_BASE = 32'h1100_BFF8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [31:0]       bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  cmp_q,
    input logic              irq
);
    localparam logic [31:0] CNT_END = CNT_BASE + 32'((CNT_W / DATA_W) * 4);

    logic wr_sel;
    logic cmp_lo_wr;
    logic cnt_wr;
    logic cmp_any_wr;

    assign wr_sel     = bus_sel & bus_we;
    assign cmp_lo_wr  = wr_sel && (bus_addr == CMP_BASE);
    assign cnt_wr     = wr_sel && (bus_addr >= CNT_BASE) && (bus_addr < CNT_END);
    assign cmp_any_wr = wr_sel && (bus_addr >= CMP_BASE) &&
                        (bus_addr < CMP_BASE + 32'((CNT_W / DATA_W) * 4));

    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count_q == $past(count_q) + 1'b1);

    p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count_q));

    p_cnt_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !tick_en) |=> $stable(count_q));

    p_cmp_lo_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_lo_wr |=> ($stable(cmp_q[CNT_W-1:DATA_W]) &&
                       cmp_q[DATA_W-1:0] == $past(bus_wdata)));

    p_cmp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_any_wr |=> $stable(cmp_q));

    p_irq_strict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == ($past(count_q) > $past(cmp_q))));
endmodule

bind mtimer_unit mtimer_unit_chk #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CMP_BASE(CMP_BASE), .CNT_BASE(CNT_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .count_q(count_w), .cmp_q(cmp_w), .irq(irq_timer)
);

// File: tb/mtimer_unit_test.sv
`timescale 1ns/1ps
module mtimer_unit_test;
    localparam logic [31:0] A_CMP_LO = 32'h1100_4000;
    localparam logic [31:0] A_CMP_HI = 32'h1100_4004;
    localparam logic [31:0] A_CNT_LO = 32'h1100_BFF8;
    localparam logic [31:0] A_CNT_HI = 32'h1100_BFFC;
    localparam logic [63:0] INIT_VAL = 64'h0000_0000_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_timer;

    int n_cmp = 0;
    int n_bad = 0;

    longint unsigned m_cnt;
    longint unsigned m_cmp;
    bit              m_irq;

    always #10 clk = ~clk;

    mtimer_unit #(.CNT_INIT(INIT_VAL)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_timer(irq_timer)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input bit sel, input bit we, input logic [31:0] a);
        if (!sel || we) return 32'h0;
        case (a)
            A_CNT_LO: return m_cnt[31:0];
            A_CNT_HI: return m_cnt[63:32];
            A_CMP_LO: return m_cmp[31:0];
            A_CMP_HI: return m_cmp[63:32];
            default:  return 32'h0;
        endcase
    endfunction

    function automatic string auto_tag(input logic [31:0] a);
        if (a == A_CNT_LO || a == A_CNT_HI) return "R5";
        if (a == A_CMP_LO || a == A_CMP_HI) return "R4";
        return "R9";
    endfunction

    // One bus cycle: drive, compare read data, clock, update model, compare irq.
    task automatic step(input bit sel, input bit we, input logic [31:0] a,
                        input logic [31:0] wd, input bit tk, input string tag);
        bit nxt_irq;
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd; tick_en = tk;
        #1;
        check((tag == "") ? auto_tag(a) : tag, {32'h0, bus_rdata},
              {32'h0, model_read(sel, we, a)});
        @(posedge clk);
        #1;
        nxt_irq = (m_cnt > m_cmp);
        if (sel && we && a == A_CMP_LO) m_cmp[31:0]  = wd;
        if (sel && we && a == A_CMP_HI) m_cmp[63:32] = wd;
        if (tk) m_cnt = m_cnt + 1;
        m_irq = nxt_irq;
        check("R7", {63'h0, irq_timer}, {63'h0, m_irq});
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] addrs [5];
        addrs[0] = A_CMP_LO; addrs[1] = A_CMP_HI; addrs[2] = A_CNT_LO;
        addrs[3] = A_CNT_HI; addrs[4] = 32'h1100_4002;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = INIT_VAL; m_cmp = '1; m_irq = 1'b0;
        #1;
        check("R1", {63'h0, irq_timer}, 64'h0);
        step(1, 0, A_CNT_LO, 0, 0, "R1");
        step(1, 0, A_CNT_HI, 0, 0, "R1");
        step(1, 0, A_CMP_LO, 0, 0, "R1");
        step(1, 0, A_CMP_HI, 0, 0, "R1");

        // R2: hold without tick, step with tick
        for (int i = 0; i < 3; i++) step(1, 0, A_CNT_LO, 0, 0, "R2");
        for (int i = 0; i < 5; i++) step(1, 0, A_CNT_LO, 0, 1, "R2");

        // R3: cross the low-word boundary while reading both words
        for (int i = 0; i < 260; i++)
            step(1, 0, (i % 2) ? A_CNT_HI : A_CNT_LO, 0, 1, "R3");
        step(1, 0, A_CNT_HI, 0, 0, "R3");
        check("R3", m_cnt[63:32], 64'h1);

        // R6: writes to the count words leave it alone
        step(1, 1, A_CNT_LO, 32'hDEAD_BEEF, 0, "R6");
        step(1, 1, A_CNT_HI, 32'h1234_5678, 0, "R6");
        step(1, 0, A_CNT_LO, 0, 0, "R6");
        step(1, 0, A_CNT_HI, 0, 0, "R6");

        // R4: program threshold three above the count, word by word
        step(1, 1, A_CMP_LO, m_cnt[31:0] + 32'd3, 0, "R4");
        step(1, 0, A_CMP_HI, 0, 0, "R4");
        step(1, 1, A_CMP_HI, m_cnt[63:32], 0, "R4");
        step(1, 0, A_CMP_LO, 0, 0, "R4");

        // R7: tick across equality into strictly greater
        for (int i = 0; i < 6; i++) step(1, 0, A_CNT_LO, 0, 1, "R7");
        check("R7", {63'h0, irq_timer}, 64'h1);

        // R8: level holds, then clears after the threshold is raised
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R8");
        check("R8", {63'h0, irq_timer}, 64'h1);
        step(1, 1, A_CMP_HI, 32'h2, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        check("R8", {63'h0, irq_timer}, 64'h0);

        // R9: unselected write, unmapped and write-cycle reads
        step(0, 1, A_CMP_LO, 32'h0, 0, "R9");
        step(1, 0, A_CMP_LO, 0, 0, "R9");
        step(1, 0, 32'h1100_4001, 0, 0, "R9");
        step(1, 1, 32'h1100_0000, 32'h55, 0, "R9");
        step(1, 0, A_CMP_HI, 0, 0, "R9");

        // Mixed traffic against the model
        lfsr = 32'hACE1_1357;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], addrs[lfsr[7:4] % 5],
                 (lfsr[8]) ? m_cnt[31:0] + {28'h0, lfsr[12:9]} : {30'h0, lfsr[14:13]},
                 lfsr[15], "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule